// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a synchronous host-side reader for a 14-bit serial converter that sits on a three-wire link. The link has an active-low select, a serial clock driven by this block, and a serial data return. When a start pulse arrives while the reader is idle, it pulls select low and runs exactly sixteen serial clock periods. Each period is a programmable number of system clocks. As the clocks run, the reader collects the sixteen-bit frame. The frame is two leading zero bits and then the result, most significant bit first. After the sixteenth period the reader releases select and delivers the result with a one-cycle strobe. It then keeps the link quiet for a programmable number of system clocks before it accepts another start.

The converter places the first leading zero on the data line as soon as select falls. It launches every later bit on a falling serial clock edge. For this reason the reader takes the first bit just before the first falling edge, and it takes the other fifteen bits on rising edges 1 to 15. The sixteenth period only completes the conversion. If either leading bit reads as one, the reader flags a framing error and still delivers the data bits.

The serial clock idles high. Each period spends its first half high and its second half low, so the falling edge lands mid-period and the rising edge closes the period. The asynchronous active-low reset is released inside the block through a two-stage synchronizer.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, and after it is released with no start given, `sel_n` is 1, `ser_clk` is 1, `busy` is 0 and `result_vld` is 0.
- R2: A `start` sampled high while `busy` is 0 drives `sel_n` to 0 and `busy` to 1 on that clock edge. `sel_n` then stays 0 for exactly 16 × `CLK_DIV` system clock cycles.
- R3: While `sel_n` is 0, `ser_clk` makes exactly 16 falling edges. Each period is `CLK_DIV` system clocks long, high for the first half and low for the second. `ser_clk` is 1 whenever `sel_n` is 1.
- R4: `ser_din` is sampled once just before the first falling edge and then on each of the first 15 rising edges. The first sample lands in frame bit 15 and the last in bit 0. `result` equals frame bits 13..0, so bit 13 is the first data bit received.
- R5: `result_vld` is high for exactly one cycle. That cycle is the first cycle in which `sel_n` is back at 1 after a frame, and `result` and `frame_err` are valid in it.
- R6: `frame_err` is 1 when frame bit 15 or frame bit 14 (the two leading bits) is 1, and 0 otherwise. `result` carries the data bits either way.
- R7: `busy` stays 1 from the start edge through `QUIET_CYC` cycles after `sel_n` rises, and then goes to 0. A `start` given while `busy` is 1 has no effect: the frame length and edge count do not change, and `sel_n` does not fall during or straight after the quiet interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame; taken only when idle |
| ser_din | input | 1 | Serial data returned by the converter |
| sel_n | output | 1 | Active-low converter select |
| ser_clk | output | 1 | Serial clock, idles high |
| result | output | RES_W | Last captured conversion result |
| result_vld | output | 1 | One-cycle strobe marking a new result |
| frame_err | output | 1 | Leading bits of the last frame were not zero |
| busy | output | 1 | Frame or quiet interval in progress |

## Verification
The converter model is fed fixed words of all zeros, all ones, alternating bits and single set leading bits, and then seeded random words. Uniform words expose a stuck sampler. Alternating and random words expose an off-by-one in sample placement or bit order, and they separate sampling on the rising edge from sampling on the falling edge. Frames whose leading bits are set separate the error flag from the data path. Some frames carry extra start pulses in mid-frame and in the quiet interval, which shows whether a busy reader really ignores requests or restarts and shortens the frame.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_XFER  = 2'd1,
    RD_QUIET = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adcfr_sclk_gen.sv
// Serial clock generator: one period per DIV system clocks, high half first.
module adcfr_sclk_gen #(
  parameter int DIV        = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ser_clk,
  output logic samp_evt,
  output logic done_evt
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = $clog2(DIV);
  localparam int PER_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             clk_q, clk_d;
  logic             fall_hit, rise_hit, first_per, last_per;

  assign fall_hit  = run && (cnt_q == CNT_W'(HALF - 1));
  assign rise_hit  = run && (cnt_q == CNT_W'(DIV - 1));
  assign first_per = (per_q == '0);
  assign last_per  = (per_q == PER_W'(FRAME_BITS - 1));

  // Leading bit is on the wire before the first fall; later bits on rises.
  assign samp_evt = (fall_hit && first_per) || (rise_hit && !last_per);
  assign done_evt = rise_hit && last_per;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    clk_d = clk_q;
    if (!run) begin
      cnt_d = '0;
      per_d = '0;
      clk_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (fall_hit) clk_d = 1'b0;
      if (rise_hit) begin
        cnt_d = '0;
        clk_d = 1'b1;
        per_d = per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      clk_q <= clk_d;
    end
  end

  assign ser_clk = clk_q;
endmodule

// File: rtl/adcfr_shifter.sv
// Frame capture register, MSB first.
module adcfr_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word;
    if (shift_en) word_d = {word[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_d;
  end
endmodule

// File: rtl/adcfr_quiet_tmr.sv
// Counts the quiet interval between frames.
module adcfr_quiet_tmr #(
  parameter int QUIET = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int QW = $clog2(QUIET + 1);

  logic [QW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == QW'(QUIET - 1));

  always_comb begin
    cnt_d = '0;
    if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int CLK_DIV   = 4,
  parameter int QUIET_CYC = 4,
  parameter int RES_W     = 14,
  parameter int LEAD_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ser_din,
  output logic             sel_n,
  output logic             ser_clk,
  output logic [RES_W-1:0] result,
  output logic             result_vld,
  output logic             frame_err,
  output logic             busy
);
  import adcfr_pkg::*;

  localparam int FRAME_BITS = RES_W + LEAD_W;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  rd_state_e              state_q, state_d;
  logic                   sel_n_q, sel_n_d;
  logic [RES_W-1:0]       res_q, res_d;
  logic                   vld_q, vld_d;
  logic                   err_q, err_d;
  logic                   xfer_run, quiet_run;
  logic                   samp_evt, done_evt, q_expire;
  logic [FRAME_BITS-1:0]  frame_word;

  assign xfer_run  = (state_q == RD_XFER);
  assign quiet_run = (state_q == RD_QUIET);

  adcfr_sclk_gen #(
    .DIV        (CLK_DIV),
    .FRAME_BITS (FRAME_BITS)
  ) u_sclk (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (xfer_run),
    .ser_clk  (ser_clk),
    .samp_evt (samp_evt),
    .done_evt (done_evt)
  );

  adcfr_shifter #(
    .W (FRAME_BITS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (srst_n),
    .shift_en (samp_evt),
    .din      (ser_din),
    .word     (frame_word)
  );

  adcfr_quiet_tmr #(
    .QUIET (QUIET_CYC)
  ) u_quiet (
    .clk    (clk),
    .rst_n  (srst_n),
    .run    (quiet_run),
    .expire (q_expire)
  );

  always_comb begin
    state_d = state_q;
    sel_n_d = sel_n_q;
    res_d   = res_q;
    err_d   = err_q;
    vld_d   = 1'b0;
    case (state_q)
      RD_IDLE: begin
        if (start) begin
          state_d = RD_XFER;
          sel_n_d = 1'b0;
        end
      end
      RD_XFER: begin
        if (done_evt) begin
          state_d = RD_QUIET;
          sel_n_d = 1'b1;
          vld_d   = 1'b1;
          res_d   = frame_word[RES_W-1:0];
          err_d   = |frame_word[FRAME_BITS-1 -: LEAD_W];
        end
      end
      RD_QUIET: begin
        if (q_expire) state_d = RD_IDLE;
      end
      default: begin
        state_d = RD_IDLE;
        sel_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= RD_IDLE;
      sel_n_q <= 1'b1;
      res_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_n_q <= sel_n_d;
      vld_q   <= vld_d;
      if (vld_d) begin
        res_q <= res_d;
        err_q <= err_d;
      end
    end
  end

  assign sel_n      = sel_n_q;
  assign result     = res_q;
  assign result_vld = vld_q;
  assign frame_err  = err_q;
  assign busy       = (state_q != RD_IDLE);
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sel_n,
  input logic ser_clk,
  input logic busy,
  input logic result_vld
);
  localparam int CW = $clog2(FRAME_BITS + 2);

  logic          sclk_prev;
  logic [CW-1:0] falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      falls     <= '0;
    end else begin
      sclk_prev <= ser_clk;
      if (sel_n)                      falls <= '0;
      else if (sclk_prev && !ser_clk) falls <= falls + 1'b1;
    end
  end

  p_sel_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> $past(start && !busy));

  p_clk_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> ser_clk);

  p_frame_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (falls == CW'(FRAME_BITS)));

  p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);

  p_vld_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> $rose(sel_n));

  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> busy);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .FRAME_BITS (RES_W + LEAD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .sel_n      (sel_n),
  .ser_clk    (ser_clk),
  .busy       (busy),
  .result_vld (result_vld)
);

// File: tb/adc_frame_reader_bench.sv
`timescale 1ns/1ps
module adc_frame_reader_bench;
  localparam int D = 4;
  localparam int Q = 4;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        ser_din;
  logic        sel_n;
  logic        ser_clk;
  logic [13:0] result;
  logic        result_vld;
  logic        frame_err;
  logic        busy;

  int n_chk;
  int n_err;
  bit done_flag;

  adc_frame_reader #(.CLK_DIV(D), .QUIET_CYC(Q), .RES_W(14), .LEAD_W(2)) u_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_din(ser_din),
    .sel_n(sel_n), .ser_clk(ser_clk), .result(result),
    .result_vld(result_vld), .frame_err(frame_err), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Converter model: first bit on select fall, later bits on clock falls.
  logic [15:0] adc_word;
  int          bit_idx;
  int          falls;
  int          idle_viol;
  bit          mon_on;

  initial begin
    ser_din  = 1'b1;
    bit_idx  = -1;
    falls    = 0;
    idle_viol = 0;
    mon_on   = 1'b0;
    adc_word = '0;
  end

  always @(negedge sel_n) begin
    bit_idx = 15;
    falls   = 0;
    ser_din = adc_word[15];
  end

  always @(posedge sel_n) ser_din = 1'b1;

  always @(negedge ser_clk) begin
    if (!sel_n) begin
      falls++;
      bit_idx--;
      ser_din = (bit_idx >= 0) ? adc_word[bit_idx] : 1'b1;
    end
  end

  always @(negedge clk) if (mon_on && sel_n && !ser_clk) idle_viol++;

  function automatic logic [13:0] exp_res(input logic [15:0] w);
    return w[13:0];
  endfunction

  function automatic logic exp_err(input logic [15:0] w);
    return w[15] | w[14];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input bit poke_mid, input bit poke_quiet);
    int n;
    adc_word = w;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sel_n == 1'b0 && busy == 1'b1, "R2 select low and busy after start", {sel_n, busy}, 2'b01);
    n = 0;
    while (!result_vld && n < 1000) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (poke_mid && n == 7) start = 1'b1;
    end
    check(n == 16 * D, "R2 select low length in cycles", n, 16 * D);
    check(falls == 16, "R3 serial clock falls per frame", falls, 16);
    check(sel_n == 1'b1, "R5 strobe in first cycle select high", sel_n, 1);
    check(result == exp_res(w), "R4 result bits", result, exp_res(w));
    check(frame_err == exp_err(w), "R6 leading bit error flag", frame_err, exp_err(w));
    for (int q = 1; q <= Q; q++) begin
      @(negedge clk);
      start = (poke_quiet && q == 1);
      if (q == 1) check(result_vld == 1'b0, "R5 strobe one cycle", result_vld, 0);
      if (q == Q - 1) check(busy == 1'b1, "R7 busy through quiet", busy, 1);
      if (q == Q) check(busy == 1'b0, "R7 busy clears after quiet", busy, 0);
    end
    start = 1'b0;
    @(negedge clk);
    check(sel_n == 1'b1, "R7 start while busy ignored", sel_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int unsigned r;
    n_chk = 0;
    n_err = 0;
    done_flag = 1'b0;
    start = 1'b0;
    rst_n = 1'b0;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 during reset
    check(sel_n && ser_clk && !busy && !result_vld, "R1 reset outputs", {sel_n, ser_clk, busy, result_vld}, 4'b1100);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release with no start
    check(sel_n && ser_clk && !busy && !result_vld, "R1 idle outputs after release", {sel_n, ser_clk, busy, result_vld}, 4'b1100);

    run_frame(16'h0000, 1'b0, 1'b0);
    run_frame(16'h3FFF, 1'b0, 1'b0);
    run_frame(16'h2AAA, 1'b1, 1'b1);
    run_frame(16'h1555, 1'b0, 1'b1);
    run_frame(16'h4001, 1'b0, 1'b0);
    run_frame(16'h8000, 1'b1, 1'b0);
    run_frame(16'hFFFF, 1'b0, 1'b0);
    for (int i = 0; i < 24; i++) begin
      r = $urandom;
      w = r[15:0];
      if (r[17:16] != 2'b00) w[15:14] = 2'b00;
      run_frame(w, r[18], r[19]);
    end

    check(idle_viol == 0, "R3 serial clock high while select high", idle_viol, 0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule